// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block holds the wall-clock time and the date as packed BCD digit fields and moves them forward by one second for every pulse on its one-per-second input. Software, through whatever register shell surrounds the block, can place a new time word, a new calendar word or a new weekday at any moment. Each load takes effect on the next clock edge, and the next second pulse counts on from the loaded value.

The hours can be shown in 24-hour form or in 12-hour form with an AM/PM marker. A single select input picks the form. It only changes how the stored hour digits are advanced and does not convert them. Midnight moves the date forward by one day. The day-of-month limit follows the month and the leap-year rule for a two-digit year covering 2000 to 2099. A weekday counter advances with the date. A one-cycle strobe tells downstream logic that a second has been counted.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the time word is 0x000000, the calendar word is 0x000101 (2000-01-01), the weekday is 0, the leap flag is 1 and tick_out is 0.
- R2: Time word fields: seconds units [3:0] (0-9), seconds tens [6:4] (0-5), minutes units [11:8], minutes tens [14:12] (0-5), hours units [19:16], hours tens [21:20]. Each second pulse adds one second with decimal carries. In 24-hour mode (hour24_sel=1) the hours run 00 to 23.
- R3: In 12-hour mode (hour24_sel=0) bit 21 is PM (1=PM) and bit 20 is the hours tens digit. The hours run 12, 01, ..., 11. The step from 11:59:59 to 12:00:00 toggles PM, and the step from 12:59:59 goes to 01:00:00 with PM unchanged.
- R4: The midnight rollover sets the time word to zero and advances the date by one day. In 24-hour mode this happens at 23:59:59. In 12-hour mode it happens at PM 11:59:59, which gives AM 12:00:00.
- R5: Calendar word fields: day units [3:0], day tens [5:4], month units [11:8], month tens [12], year units [19:16], year tens [23:20]. Months 04, 06, 09 and 11 end after day 30, February after day 28 or 29, and the other months after day 31. Day and month restart at 01. December rolls to January of the next year, and year 99 rolls to 00.
- R6: leap_year is 1 exactly when the BCD year is divisible by 4. February then has 29 days.
- R7: The weekday counts 0 to 6 and advances (6 wraps to 0) at each midnight rollover. A weekday load of 7 or more stores 0.
- R8: A time, calendar or weekday load is visible on the next clock edge. A load wins over a second pulse or midnight carry arriving in the same cycle for its own word. The next pulse counts on from the loaded value.
- R9: With the registered tick variant, tick_out is high for exactly the cycle after each clock edge that samples sec_pulse high.
- R10: Without a second pulse and without a load, the time word and the calendar word hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_pulse | input | 1 | One-cycle pulse per second |
| hour24_sel | input | 1 | 1 = 24-hour scale, 0 = 12-hour with PM bit |
| time_load | input | 1 | Load time_wdata into the time word |
| time_wdata | input | 22 | Packed BCD time to load |
| cal_load | input | 1 | Load cal_wdata into the calendar word |
| cal_wdata | input | 24 | Packed BCD date to load |
| wday_load | input | 1 | Load wday_wdata into the weekday |
| wday_wdata | input | WDAY_W | Weekday to load |
| time_word | output | 22 | Current packed BCD time |
| cal_word | output | 24 | Current packed BCD date |
| weekday | output | WDAY_W | Current weekday |
| leap_year | output | 1 | Current year is a leap year |
| tick_out | output | 1 | Second-counted strobe |

## Verification
Two pairs of events can meet in one cycle. A time load can land on the same edge as a second pulse. A calendar load can land on the edge where a pulse carries the time through midnight. The bench drives both inputs together on one falling edge. It then expects the loaded word unchanged, with no extra second counted. In the midnight case it also expects the time to wrap to zero and the weekday to advance, because those are not touched by the calendar load. Sweeps over every day of eight years and every month-end of all hundred years check the date arithmetic against a counter model kept in plain integers.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;
   localparam int TIME_W = 22;
   localparam int CAL_W  = 24;
   localparam logic [TIME_W-1:0] TIME_MASK = 22'h3F7F7F;
   localparam logic [CAL_W-1:0]  CAL_MASK  = 24'hFF1F3F;
   localparam logic [CAL_W-1:0]  CAL_RESET = 24'h000101;

   // one BCD digit plus one, wrapping at the given top value
   function automatic logic [3:0] dig_inc(input logic [3:0] d, input logic [3:0] top);
      return (d == top) ? 4'd0 : 4'(d + 4'd1);
   endfunction

   // two-digit BCD year divisible by four
   function automatic logic year_is_leap(input logic [7:0] y);
      if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
      else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
   endfunction

   // last day of a BCD month as BCD
   function automatic logic [7:0] month_end(input logic [7:0] mon, input logic leap);
      if (mon == 8'h02) return leap ? 8'h29 : 8'h28;
      if (mon == 8'h04 || mon == 8'h06 || mon == 8'h09 || mon == 8'h11) return 8'h30;
      return 8'h31;
   endfunction
endpackage

// File: rtl/rtc_time_unit.sv
module rtc_time_unit
   import rtc_bcd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              load,
   input  logic [TIME_W-1:0] load_val,
   input  logic              hour24,
   output logic [TIME_W-1:0] time_q,
   output logic              day_carry
);
   logic [3:0] su, mu, hu, su_n, mu_n, hu_n;
   logic [2:0] st, mt, st_n, mt_n;
   logic [1:0] ht, ht_n;
   logic       sec_wrap, min_wrap, hour_wrap;

   assign su = time_q[3:0];
   assign st = time_q[6:4];
   assign mu = time_q[11:8];
   assign mt = time_q[14:12];
   assign hu = time_q[19:16];
   assign ht = time_q[21:20];

   assign sec_wrap = (su == 4'd9) && (st == 3'd5);
   assign min_wrap = sec_wrap && (mu == 4'd9) && (mt == 3'd5);

   always_comb begin
      su_n = dig_inc(su, 4'd9);
      st_n = (su == 4'd9) ? ((st == 3'd5) ? 3'd0 : 3'(st + 3'd1)) : st;
      mu_n = sec_wrap ? dig_inc(mu, 4'd9) : mu;
      mt_n = (sec_wrap && mu == 4'd9) ? ((mt == 3'd5) ? 3'd0 : 3'(mt + 3'd1)) : mt;
      hu_n = hu;
      ht_n = ht;
      hour_wrap = 1'b0;
      if (min_wrap) begin
         if (hour24) begin
            if (ht == 2'd2 && hu == 4'd3) begin
               hu_n = 4'd0;
               ht_n = 2'd0;
               hour_wrap = 1'b1;
            end else if (hu == 4'd9) begin
               hu_n = 4'd0;
               ht_n = 2'(ht + 2'd1);
            end else begin
               hu_n = 4'(hu + 4'd1);
            end
         end else begin
            // bit 1 of ht is the PM marker, bit 0 the tens digit
            if (ht[0] && hu == 4'd1) begin
               hu_n = 4'd2;
               ht_n = {~ht[1], 1'b1};
               hour_wrap = ht[1];
            end else if (ht[0] && hu == 4'd2) begin
               hu_n = 4'd1;
               ht_n = {ht[1], 1'b0};
            end else if (hu == 4'd9) begin
               hu_n = 4'd0;
               ht_n = {ht[1], 1'b1};
            end else begin
               hu_n = 4'(hu + 4'd1);
            end
         end
      end
   end

   assign day_carry = adv && !load && hour_wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    time_q <= '0;
      else if (load) time_q <= load_val & TIME_MASK;
      else if (adv)  time_q <= {ht_n, hu_n, 1'b0, mt_n, mu_n, 1'b0, st_n, su_n};
   end
endmodule

// File: rtl/rtc_date_unit.sv
module rtc_date_unit
   import rtc_bcd_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             load,
   input  logic [CAL_W-1:0] load_val,
   output logic [CAL_W-1:0] cal_q,
   output logic             leap
);
   logic [7:0] day, mon, yr, day_n, mon_n, yr_n;

   assign day  = {2'b00, cal_q[5:0]};
   assign mon  = {3'b000, cal_q[12:8]};
   assign yr   = cal_q[23:16];
   assign leap = year_is_leap(yr);

   always_comb begin
      day_n = day;
      mon_n = mon;
      yr_n  = yr;
      if (day == month_end(mon, leap)) begin
         day_n = 8'h01;
         if (mon == 8'h12) begin
            mon_n = 8'h01;
            yr_n  = {(yr[3:0] == 4'd9) ? dig_inc(yr[7:4], 4'd9) : yr[7:4], dig_inc(yr[3:0], 4'd9)};
         end else if (mon[3:0] == 4'd9) begin
            mon_n = 8'h10;
         end else begin
            mon_n = {mon[7:4], 4'(mon[3:0] + 4'd1)};
         end
      end else if (day[3:0] == 4'd9) begin
         day_n = {4'(day[7:4] + 4'd1), 4'd0};
      end else begin
         day_n = {day[7:4], 4'(day[3:0] + 4'd1)};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cal_q <= CAL_RESET;
      else if (load) cal_q <= load_val & CAL_MASK;
      else if (adv)  cal_q <= {yr_n, 3'b000, mon_n[4:0], 2'b00, day_n[5:0]};
   end
endmodule

// File: rtl/rtc_wday_unit.sv
module rtc_wday_unit #(
   parameter int WDAY_W     = 3,
   parameter int WDAY_COUNT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              load,
   input  logic [WDAY_W-1:0] load_val,
   output logic [WDAY_W-1:0] wday_q
);
   localparam logic [WDAY_W-1:0] LAST = WDAY_W'(WDAY_COUNT - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    wday_q <= '0;
      else if (load) wday_q <= (load_val > LAST) ? '0 : load_val;
      else if (adv)  wday_q <= (wday_q == LAST) ? '0 : WDAY_W'(wday_q + 1'b1);
   end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
   import rtc_bcd_pkg::*;
#(
   parameter int WDAY_W     = 3,
   parameter int WDAY_COUNT = 7,
   parameter int TICK_STAGE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_pulse,
   input  logic              hour24_sel,
   input  logic              time_load,
   input  logic [TIME_W-1:0] time_wdata,
   input  logic              cal_load,
   input  logic [CAL_W-1:0]  cal_wdata,
   input  logic              wday_load,
   input  logic [WDAY_W-1:0] wday_wdata,
   output logic [TIME_W-1:0] time_word,
   output logic [CAL_W-1:0]  cal_word,
   output logic [WDAY_W-1:0] weekday,
   output logic              leap_year,
   output logic              tick_out
);
   if (WDAY_COUNT < 2 || WDAY_COUNT > (1 << WDAY_W))
      $error("bcd_rtc_core: WDAY_COUNT does not fit WDAY_W");
   if (TICK_STAGE < 0 || TICK_STAGE > 1)
      $error("bcd_rtc_core: TICK_STAGE must be 0 or 1");

   logic day_carry;

   rtc_time_unit u_time (
      .clk(clk), .rst_n(rst_n), .adv(sec_pulse), .load(time_load),
      .load_val(time_wdata), .hour24(hour24_sel),
      .time_q(time_word), .day_carry(day_carry)
   );

   rtc_date_unit u_date (
      .clk(clk), .rst_n(rst_n), .adv(day_carry), .load(cal_load),
      .load_val(cal_wdata), .cal_q(cal_word), .leap(leap_year)
   );

   rtc_wday_unit #(.WDAY_W(WDAY_W), .WDAY_COUNT(WDAY_COUNT)) u_wday (
      .clk(clk), .rst_n(rst_n), .adv(day_carry), .load(wday_load),
      .load_val(wday_wdata), .wday_q(weekday)
   );

   if (TICK_STAGE == 1) begin : g_tick_reg
      logic tick_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tick_q <= 1'b0;
         else        tick_q <= sec_pulse;
      end
      assign tick_out = tick_q;
   end else begin : g_tick_comb
      assign tick_out = sec_pulse;
   end
endmodule

// File: rtl/bcd_rtc_core_chk.sv
module bcd_rtc_core_chk
   import rtc_bcd_pkg::*;
#(
   parameter int WDAY_W     = 3,
   parameter int WDAY_COUNT = 7,
   parameter int TICK_STAGE = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sec_pulse,
   input logic              time_load,
   input logic [TIME_W-1:0] time_wdata,
   input logic              cal_load,
   input logic [CAL_W-1:0]  cal_wdata,
   input logic [TIME_W-1:0] time_word,
   input logic [CAL_W-1:0]  cal_word,
   input logic [WDAY_W-1:0] weekday,
   input logic              tick_out
);
   if (TICK_STAGE == 1) begin : g_tick_props
      a_r9_tick_follows: assert property (@(posedge clk) disable iff (!rst_n)
         sec_pulse |=> tick_out);
      a_r9_tick_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         !sec_pulse |=> !tick_out);
   end

   a_r10_time_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_pulse && !time_load) |=> $stable(time_word));

   a_r10_cal_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_pulse && !cal_load) |=> $stable(cal_word));

   a_r8_time_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      time_load |=> (time_word == ($past(time_wdata) & TIME_MASK)));

   a_r8_cal_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      cal_load |=> (cal_word == ($past(cal_wdata) & CAL_MASK)));

   a_r7_wday_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      weekday < WDAY_W'(WDAY_COUNT));

   a_r2_sec_units_decimal: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_pulse && !time_load) |=> (time_word[3:0] <= 4'd9 && time_word[6:4] <= 3'd5));
endmodule

bind bcd_rtc_core bcd_rtc_core_chk #(
   .WDAY_W(WDAY_W), .WDAY_COUNT(WDAY_COUNT), .TICK_STAGE(TICK_STAGE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sec_pulse(sec_pulse), .time_load(time_load),
   .time_wdata(time_wdata), .cal_load(cal_load), .cal_wdata(cal_wdata),
   .time_word(time_word), .cal_word(cal_word), .weekday(weekday), .tick_out(tick_out)
);

// File: tb/bcd_rtc_core_test.sv
module bcd_rtc_core_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sec_pulse = 1'b0;
   logic        hour24_sel = 1'b1;
   logic        time_load = 1'b0;
   logic [21:0] time_wdata = '0;
   logic        cal_load = 1'b0;
   logic [23:0] cal_wdata = '0;
   logic        wday_load = 1'b0;
   logic [2:0]  wday_wdata = '0;
   logic [21:0] time_word;
   logic [23:0] cal_word;
   logic [2:0]  weekday;
   logic        leap_year;
   logic        tick_out;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   int m_secs = 0, m_d = 1, m_mo = 1, m_y = 0, m_wd = 0;
   bit m24 = 1'b1;

   always #(CLK_PERIOD/2) clk = ~clk;

   bcd_rtc_core uut (
      .clk(clk), .rst_n(rst_n), .sec_pulse(sec_pulse), .hour24_sel(hour24_sel),
      .time_load(time_load), .time_wdata(time_wdata), .cal_load(cal_load),
      .cal_wdata(cal_wdata), .wday_load(wday_load), .wday_wdata(wday_wdata),
      .time_word(time_word), .cal_word(cal_word), .weekday(weekday),
      .leap_year(leap_year), .tick_out(tick_out)
   );

   function automatic logic [21:0] enc_time(int s, bit h24);
      int h = s / 3600, mi = (s / 60) % 60, se = s % 60, h12;
      logic [7:0] mins = {1'b0, 3'(mi / 10), 4'(mi % 10)};
      logic [7:0] secs = {1'b0, 3'(se / 10), 4'(se % 10)};
      if (h24) return {2'(h / 10), 4'(h % 10), mins, secs};
      h12 = (h % 12 == 0) ? 12 : h % 12;
      return {1'(h >= 12), 1'(h12 / 10), 4'(h12 % 10), mins, secs};
   endfunction

   function automatic logic [23:0] enc_cal(int d, int mo, int y);
      return {4'(y / 10), 4'(y % 10), 3'b000, 1'(mo / 10), 4'(mo % 10), 2'b00, 2'(d / 10), 4'(d % 10)};
   endfunction

   function automatic int dim(int mo, int y);
      if (mo == 2) return (y % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_day();
      m_d++;
      if (m_d > dim(m_mo, m_y)) begin
         m_d = 1;
         m_mo++;
         if (m_mo > 12) begin
            m_mo = 1;
            m_y = (m_y + 1) % 100;
         end
      end
   endtask

   task automatic model_tick(bit cal_loaded);
      m_secs++;
      if (m_secs == 86400) begin
         m_secs = 0;
         m_wd = (m_wd + 1) % 7;
         if (!cal_loaded) model_day();
      end
   endtask

   // one clock of stimulus driven at a falling edge, released at the next one
   task automatic step(bit p, bit tl, logic [21:0] tv, bit cl, logic [23:0] cv, bit wl, logic [2:0] wv);
      @(negedge clk);
      sec_pulse = p; time_load = tl; time_wdata = tv;
      cal_load = cl; cal_wdata = cv; wday_load = wl; wday_wdata = wv;
      @(negedge clk);
      sec_pulse = 1'b0; time_load = 1'b0; cal_load = 1'b0; wday_load = 1'b0;
   endtask

   task automatic check_all(string tag, bit exp_tick);
      check({tag, " time"}, 32'(time_word), 32'(enc_time(m_secs, m24)));
      check({tag, " cal"}, 32'(cal_word), 32'(enc_cal(m_d, m_mo, m_y)));
      check({tag, " weekday R7"}, 32'(weekday), 32'(m_wd));
      check({tag, " leap R6"}, 32'(leap_year), 32'(m_y % 4 == 0));
      check({tag, " tick R9"}, 32'(tick_out), 32'(exp_tick));
   endtask

   task automatic load_time(int s);
      step(0, 1, enc_time(s, m24), 0, '0, 0, '0);
      m_secs = s;
   endtask

   task automatic tick(string tag);
      step(1, 0, '0, 0, '0, 0, '0);
      model_tick(1'b0);
      check_all(tag, 1'b1);
   endtask

   task automatic run(string tag, int n);
      for (int i = 0; i < n; i++) tick(tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 reset", 1'b0);

      // R10: idle cycles leave all words unchanged
      repeat (5) @(negedge clk);
      check_all("R10 idle", 1'b0);

      // R2: first hour and a bit in 24-hour mode
      run("R2 24h sweep", 3700);

      // R4: across midnight in 24-hour mode
      load_time(86280);
      run("R4 24h midnight", 200);

      // R3: 12-hour mode around noon, 12:59 and 00:59
      hour24_sel = 1'b0; m24 = 1'b0;
      load_time(43080); run("R3 12h noon", 200);
      load_time(46710); run("R3 12h one pm", 100);
      load_time(3540);  run("R3 12h one am", 100);
      load_time(86340); run("R4 12h midnight", 120);

      // R5 R6 R7: every day of eight years
      hour24_sel = 1'b1; m24 = 1'b1;
      step(0, 0, '0, 1, enc_cal(1, 1, 0), 1, 3'd0);
      m_d = 1; m_mo = 1; m_y = 0; m_wd = 0;
      for (int i = 0; i < 2922; i++) begin
         load_time(86399);
         tick("R5 day sweep");
      end

      // R5 R6: every month end of every year
      for (int y = 0; y < 100; y++) begin
         for (int mo = 1; mo <= 12; mo++) begin
            step(0, 1, enc_time(86399, 1'b1), 1, enc_cal(dim(mo, y), mo, y), 0, '0);
            m_secs = 86399; m_d = dim(mo, y); m_mo = mo; m_y = y;
            tick("R5 month end");
         end
      end

      // R8: time load in the same cycle as a second pulse
      load_time(1000);
      step(1, 1, enc_time(5000, 1'b1), 0, '0, 0, '0);
      m_secs = 5000;
      check_all("R8 load vs pulse", 1'b1);
      tick("R8 after load");

      // R8: calendar load on the midnight carry edge
      load_time(86399);
      step(1, 0, '0, 1, enc_cal(15, 7, 31), 0, '0);
      model_tick(1'b1);
      m_d = 15; m_mo = 7; m_y = 31;
      check_all("R8 load vs carry", 1'b1);

      // R7: out-of-range weekday load, then wrap from 6
      step(0, 0, '0, 0, '0, 1, 3'd7);
      m_wd = 0;
      check_all("R7 load seven", 1'b0);
      step(0, 0, '0, 0, '0, 1, 3'd6);
      m_wd = 6;
      load_time(86399);
      tick("R7 wrap");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule